// File: doc/BRIEF.md
# Two-Level Class Memory Request Arbiter

This block sits in front of a memory controller and decides which of eight request queues is served next. Every queue is bound by its index to one of three priority classes. A first level picks one queue inside each class, and a second level picks one class. Class 0 always wins when it has work. Between class 1 and class 2 the split of grants is programmable.

The decision logic is combinational. In the cycle a grant is taken, the chosen queue sees a one-cycle pop strobe, and the winning index is captured in an output register that drives the master port. That register holds its content while the downstream side is not ready. It accepts a new grant only when it is empty or is being drained in the same cycle.

Top module: `class_mem_arbiter`

## Requirements
- R1: Queues 6 and 7 form class 0, queues 0 and 1 form class 1, and queues 2 to 5 form class 2. A pop is only ever raised for a queue whose valid bit is high.
- R2: While either class 0 queue is valid, every grant goes to a class 0 queue, whatever classes 1 and 2 request.
- R3: Inside a class, queues are served round-robin. The pointer starts at the lowest queue of the class and moves just past a queue only when that queue is popped. Queues that are not requesting are skipped.
- R4: When class 1 and class 2 both request and class 0 does not, class 1 takes up to `share_n` such contested grants in a row and then class 2 takes one. A `share_n` value of 0 acts as 1.
- R5: When only one of class 1 and class 2 requests, that class is granted, and the share counter keeps its value.
- R6: `pop` is one-hot or zero and is raised in the same cycle the grant is decided. On the next clock edge `out_valid` is 1 and `out_qidx` holds that queue's index (3-bit binary).
- R7: While `out_valid` is 1 and `dn_ready` is 0, `out_qidx` and `out_valid` hold, `pop` stays zero and no round-robin pointer moves.
- R8: When the output stage can load and no queue is valid, `out_valid` goes to 0 on the next edge, and the pointers and share counter keep their values.
- R9: Reset clears `out_valid`, zeroes the share counter and puts every round-robin pointer on the lowest queue of its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 8 | Per-queue request pending, bit i for queue i |
| share_n | input | 4 | Contested class 1 grants allowed before one class 2 grant |
| dn_ready | input | 1 | Downstream accepts the output register this cycle |
| out_valid | output | 1 | Output register holds a grant |
| out_qidx | output | 3 | Registered index of the granted queue |
| pop | output | 8 | One-cycle strobe to the queue being granted |

## Verification
The bench uses the default eight-queue, three-class map with a 4-bit share field and drives `share_n` at 0, 1, 2 and 15. That covers the smallest legal share, the zero-as-one case, a two-to-one pattern and a class 1 run that never ends while class 2 is idle. With the default map, both a two-queue class and a four-queue class are present. This brings pointer wrap, skipping over idle queues, and pointer behaviour across stalls and idle cycles within reach in a handful of directed cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_Q   = 8;
  localparam int QW      = $clog2(NUM_Q);
  localparam int NUM_CLS = 3;
  localparam int SHARE_W = 4;

  // First queue index owned by a class
  function automatic int cls_base(input int c);
    case (c)
      0:       return 6;
      1:       return 0;
      default: return 2;
    endcase
  endfunction

  // Number of queues owned by a class
  function automatic int cls_cnt(input int c);
    case (c)
      0:       return 2;
      1:       return 2;
      default: return 4;
    endcase
  endfunction

  // Effective share limit: zero behaves like one
  function automatic logic [SHARE_W-1:0] eff_share(input logic [SHARE_W-1:0] n);
    return (n == '0) ? SHARE_W'(1) : n;
  endfunction

  function automatic logic [NUM_Q-1:0] q_onehot(input logic [QW-1:0] idx);
    return NUM_Q'(1) << idx;
  endfunction
endpackage

// File: rtl/arb_rr_class.sv
module arb_rr_class #(
  parameter int N    = 2,
  parameter int BASE = 0,
  parameter int QW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          any,
  output logic [QW-1:0] win
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] pick;
  logic          found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = PW'(idx);
      end
    end
  end

  assign any = |req;
  assign win = QW'(BASE) + QW'(pick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (adv)
      ptr <= (int'(pick) == N - 1) ? '0 : pick + PW'(1);
  end

  AST_RR_PICK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[pick]) else $error("rr pick not requesting"); // R3

  AST_RR_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr)) else $error("rr pointer moved without pop"); // R3
endmodule

// File: rtl/arb_share_ctl.sv
module arb_share_ctl
  import arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHARE_W-1:0] share_n,
  input  logic               c0_any,
  input  logic               c1_any,
  input  logic               c2_any,
  input  logic               take,
  output logic               pick_c2
);
  logic [SHARE_W-1:0] run_cnt;
  logic [SHARE_W-1:0] limit;
  logic               contested;

  assign limit     = eff_share(share_n);
  assign contested = !c0_any && c1_any && c2_any;
  assign pick_c2   = contested && (run_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (take && contested)
      run_cnt <= pick_c2 ? '0 : run_cnt + SHARE_W'(1);
  end

  AST_SHARE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && contested) |=> $stable(run_cnt)) else $error("share counter moved"); // R5
endmodule

// File: rtl/arb_out_stage.sv
module arb_out_stage #(
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          have_win,
  input  logic [QW-1:0] win_q,
  input  logic          dn_ready,
  output logic          load_en,
  output logic          out_valid,
  output logic [QW-1:0] out_qidx
);
  assign load_en = !out_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_qidx  <= '0;
    end else if (load_en) begin
      out_valid <= have_win;
      if (have_win) out_qidx <= win_q;
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dn_ready) |=> (out_valid && $stable(out_qidx))) else $error("stall lost"); // R7

  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !have_win) |=> !out_valid) else $error("idle valid"); // R8
endmodule

// File: rtl/class_mem_arbiter.sv
module class_mem_arbiter
  import arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_Q-1:0]   req_valid,
  input  logic [SHARE_W-1:0] share_n,
  input  logic               dn_ready,
  output logic               out_valid,
  output logic [QW-1:0]      out_qidx,
  output logic [NUM_Q-1:0]   pop
);
  logic [NUM_CLS-1:0] cls_any;
  logic [QW-1:0]      cls_win [NUM_CLS];
  logic [NUM_CLS-1:0] cls_adv;
  logic [1:0]         sel_cls;
  logic               have_win;
  logic [QW-1:0]      win_q;
  logic               load_en;
  logic               take;
  logic               pick_c2;

  // First level: one round-robin picker per class
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam int B = cls_base(c);
    localparam int N = cls_cnt(c);
    arb_rr_class #(.N(N), .BASE(B), .QW(QW)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_valid[B +: N]),
      .adv   (cls_adv[c]),
      .any   (cls_any[c]),
      .win   (cls_win[c])
    );
    assign cls_adv[c] = take && (sel_cls == 2'(c));
  end

  arb_share_ctl u_share (
    .clk     (clk),
    .rst_n   (rst_n),
    .share_n (share_n),
    .c0_any  (cls_any[0]),
    .c1_any  (cls_any[1]),
    .c2_any  (cls_any[2]),
    .take    (take),
    .pick_c2 (pick_c2)
  );

  // Second level: class 0 strict, then share between classes 1 and 2
  always_comb begin
    if (cls_any[0])                  sel_cls = 2'd0;
    else if (cls_any[1] && !pick_c2) sel_cls = 2'd1;
    else                             sel_cls = 2'd2;
  end

  assign have_win = |cls_any;
  assign win_q    = cls_win[sel_cls];
  assign take     = load_en && have_win;
  assign pop      = take ? q_onehot(win_q) : '0;

  arb_out_stage #(.QW(QW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_win  (have_win),
    .win_q     (win_q),
    .dn_ready  (dn_ready),
    .load_en   (load_en),
    .out_valid (out_valid),
    .out_qidx  (out_qidx)
  );

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop)) else $error("pop not onehot"); // R6

  AST_POP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop & ~req_valid) == '0) else $error("pop on idle queue"); // R1

  AST_C0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_valid[7:6]) && (|pop)) |-> (|pop[7:6])) else $error("class 0 bypassed"); // R2

  AST_POP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (|pop) |=> (out_valid && out_qidx == $past(win_q))) else $error("pop not registered"); // R6

  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !dn_ready) |-> (pop == '0)) else $error("pop during stall"); // R7
endmodule

// File: tb/sim_class_mem_arbiter.sv
module sim_class_mem_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_valid = '0;
  logic [3:0] share_n = 4'd1;
  logic       dn_ready = 1'b1;
  logic       out_valid;
  logic [2:0] out_qidx;
  logic [7:0] pop;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  class_mem_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .share_n(share_n),
    .dn_ready(dn_ready), .out_valid(out_valid), .out_qidx(out_qidx), .pop(pop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = '0; dn_ready = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset pop", int'(pop), 0);
    rst_n = 1'b1;
  endtask

  // Drive one cycle; exp_pop < 0 means no grant taken.
  task automatic step(input logic [7:0] r, input logic rdy, input int exp_pop,
                      input int exp_v, input int exp_q, input string tag);
    @(negedge clk);
    req_valid = r; dn_ready = rdy;
    #2;
    chk({tag, " pop"}, int'(pop), (exp_pop < 0) ? 0 : (1 << exp_pop));
    @(posedge clk);
    #2;
    chk({tag, " out_valid"}, int'(out_valid), exp_v);
    if (exp_v != 0) chk({tag, " out_qidx"}, int'(out_qidx), exp_q);
  endtask

  task automatic grant(input logic [7:0] r, input int q, input string tag);
    step(r, 1'b1, q, 1, q, tag);
  endtask

  task automatic t_class0();
    do_reset();
    grant(8'hFF, 6, "R2 c0 first");
    grant(8'hFF, 7, "R2 c0 rr");
    grant(8'hFF, 6, "R2 c0 wrap");
    grant(8'h43, 6, "R1 q6 class0");
  endtask

  task automatic t_rr();
    do_reset();
    share_n = 4'd15;
    grant(8'h03, 0, "R3 c1 q0");
    grant(8'h03, 1, "R3 c1 q1");
    grant(8'h03, 0, "R3 c1 wrap");
    do_reset();
    grant(8'h3C, 2, "R3 c2 q2");
    grant(8'h3C, 3, "R3 c2 q3");
    grant(8'h3C, 4, "R3 c2 q4");
    grant(8'h3C, 5, "R3 c2 q5");
    grant(8'h3C, 2, "R3 c2 wrap");
    grant(8'h24, 5, "R3 skip to q5");
    grant(8'h24, 2, "R3 skip to q2");
  endtask

  task automatic t_share();
    do_reset();
    share_n = 4'd2;
    grant(8'h0F, 0, "R4 n2 a");
    grant(8'h0F, 1, "R4 n2 b");
    grant(8'h0F, 2, "R4 n2 c2 turn");
    grant(8'h0F, 0, "R4 n2 d");
    grant(8'h0F, 1, "R4 n2 e");
    grant(8'h0F, 3, "R4 n2 c2 turn2");
    do_reset();
    share_n = 4'd0;
    grant(8'h0F, 0, "R4 n0 a");
    grant(8'h0F, 2, "R4 n0 c2");
    grant(8'h0F, 1, "R4 n0 b");
    grant(8'h0F, 3, "R4 n0 c2b");
  endtask

  task automatic t_uncontested();
    do_reset();
    share_n = 4'd1;
    grant(8'h01, 0, "R5 only c1 a");
    grant(8'h01, 0, "R5 only c1 b");
    grant(8'h01, 0, "R5 only c1 c");
    grant(8'h05, 0, "R5 counter kept");
    grant(8'h05, 2, "R5 then c2");
    grant(8'h04, 2, "R5 only c2");
  endtask

  task automatic t_stall();
    do_reset();
    share_n = 4'd15;
    step(8'h03, 1'b0, 0, 1, 0, "R6 load into empty");
    step(8'h03, 1'b0, -1, 1, 0, "R7 hold a");
    step(8'h03, 1'b0, -1, 1, 0, "R7 hold b");
    step(8'h03, 1'b1, 1, 1, 1, "R7 ptr kept");
    step(8'h00, 1'b1, -1, 0, 0, "R8 drain idle");
  endtask

  task automatic t_idle();
    do_reset();
    share_n = 4'd1;
    grant(8'h3C, 2, "R8 first");
    step(8'h00, 1'b1, -1, 0, 0, "R8 idle a");
    step(8'h00, 1'b1, -1, 0, 0, "R8 idle b");
    grant(8'h3C, 3, "R8 ptr kept");
    grant(8'h05, 0, "R8 share kept");
    do_reset();
    grant(8'h3C, 2, "R9 ptr reset");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_class0();
    t_rr();
    t_share();
    t_uncontested();
    t_stall();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule